// File: doc/BRIEF.md
# Banked Flash Sector Map and Access Arbiter

This block sits between the command decoder and the array of a four-bank flash model with simultaneous read and write. Each request carries a 22-bit word address and a request kind. The block resolves the address to a bank and to a device-wide sector number. The two outer banks are smaller than the two inner ones, and each outer bank holds small boot sectors at its extreme end. The block also makes two decisions for the request. A read is steered either to array data or to the status word. A program or erase request is either permitted or denied.

The steering decision uses the single embedded operation that may be in flight in one bank. That operation may be running or suspended. Reads to any other bank always see array data with no extra cycle. Reads to the busy bank see status, except where a suspend opens the bank up to reads. The permit decision combines four things: the write-protect pin, the per-sector persistent lock bitmap, the rule that only one embedded operation may be active at a time, and the limits that a suspend places on new work. All results are registered once, so each answer appears one clock after its request.

Top module: `flash_bank_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `out_permit` and `out_status_sel` are 0, and `out_bank` and `out_sector` are 0.
- R2: When `req_valid` is high at a clock edge, `out_valid` is high in the following cycle and carries the results for that request. When `req_valid` is low, `out_valid` is low in the following cycle.
- R3: `out_bank` is 0 for word addresses 0 to 524287, 1 for 524288 to 2097151, 2 for 2097152 to 3670015, and 3 for 3670016 to 4194303.
- R4: `out_sector` numbers the 142 sectors from the lowest address upward. Sectors 0 to 7 are 4096 words each, starting at 0. Sectors 8 to 22 are 32768 words each. Sectors 23 to 70 (bank 1) and 71 to 118 (bank 2) are 32768 words each. Sectors 119 to 133 are 32768 words each. Sectors 134 to 141 are 4096 words each and end at the top of the space.
- R5: A read (`req_kind` 0) selects array data (`out_status_sel` 0) when `busy_valid` is 0, or when `busy_bank` differs from the addressed bank.
- R6: A read to the bank named by `busy_bank`, with `busy_valid` 1 and `susp_mode` 0 (no suspend), selects the status word (`out_status_sel` 1).
- R7: With `susp_mode` 1 (erase suspended), a read selects status only if it targets the busy bank and its sector bit in `erase_sel` is set. A program (`req_kind` 1) is permitted only to a sector whose `erase_sel` bit is clear. An erase (`req_kind` 2) is denied.
- R8: With `susp_mode` 2 (program suspended), a read selects status only if its sector equals `prog_sector` in the busy bank. Every program and erase request is denied.
- R9: With `busy_valid` 1 and `susp_mode` 0, every program and erase request is denied, whichever bank it targets.
- R10: With `wp_n` low, program and erase are denied on sectors 0, 1, 140 and 141. With `wp_n` high, the pin does not affect the permit decision.
- R11: A set bit `lock_map[s]` denies program and erase on sector s and on no other sector.
- R12: A read always returns `out_permit` 0. A program or erase that none of R7 to R11 forbids returns `out_permit` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 22 | Word address of the request |
| req_kind | input | 2 | 0 read, 1 program, 2 erase |
| busy_valid | input | 1 | An embedded operation occupies a bank |
| busy_bank | input | 2 | Bank holding the embedded operation |
| susp_mode | input | 2 | 0 none, 1 erase suspended, 2 program suspended |
| erase_sel | input | 142 | Sectors selected by the active erase |
| prog_sector | input | 8 | Sector of the suspended program |
| wp_n | input | 1 | Write-protect pin, active low |
| lock_map | input | 142 | Persistent per-sector lock bits |
| out_valid | output | 1 | Results below belong to last cycle's request |
| out_bank | output | 2 | Addressed bank |
| out_sector | output | 8 | Device-wide sector number |
| out_status_sel | output | 1 | 1 selects the status word, 0 selects array data |
| out_permit | output | 1 | Program or erase allowed |

## Verification
Some rules hold on every cycle, and the bound checker watches those against the request context it captured. A permit is never granted on a locked sector, on a protected boot sector with the pin low, while an operation runs unsuspended, or during a program suspend. Status is selected only for the busy bank. Reads never carry a permit, and outer-bank sector numbers stay inside their own bank. The exact address-to-sector boundaries, and the cases where a suspend turns status back into array data, can be shown only by the bench. So can the case where one lock bit leaves its neighbours writable. The bench sweeps the first, middle and last word of every sector, and each lock bit and each protected sector in turn.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_PROG  = 2'd1,
        REQ_ERASE = 2'd2,
        REQ_RSVD  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        SUSP_NONE  = 2'd0,
        SUSP_ERASE = 2'd1,
        SUSP_PROG  = 2'd2,
        SUSP_RSVD  = 2'd3
    } susp_e;

    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_STATUS = 1'b1
    } rd_src_e;

    // Reasons a write request is refused; permit requires all clear.
    typedef struct packed {
        logic lock_hit;
        logic wp_hit;
        logic busy_hit;
        logic suspend_hit;
    } deny_t;

    // Upper bound (exclusive) of bank idx in words.
    function automatic int bank_top(input int idx, input int sw, input int bw,
                                    input int bc, input int eb, input int mb);
        int edge_words;
        int mid_words;
        edge_words = (bc << sw) + (eb << bw);
        mid_words  = mb << bw;
        case (idx)
            0:       return edge_words;
            1:       return edge_words + mid_words;
            2:       return edge_words + 2 * mid_words;
            default: return 2 * edge_words + 2 * mid_words;
        endcase
    endfunction

    function automatic int sector_count(input int bc, input int eb, input int mb);
        return 2 * (bc + eb + mb);
    endfunction

    function automatic logic is_write_kind(input req_kind_e k);
        return (k == REQ_PROG) || (k == REQ_ERASE);
    endfunction

endpackage

// File: rtl/flash_sector_decode.sv
module flash_sector_decode
    import flash_map_pkg::*;
#(
    parameter int SMALL_W      = 12,
    parameter int BIG_W        = 15,
    parameter int BOOT_CNT     = 8,
    parameter int EDGE_BIG_CNT = 15,
    parameter int MID_BIG_CNT  = 48,
    localparam int TOTAL_WORDS = bank_top(3, SMALL_W, BIG_W, BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT),
    localparam int ADDR_W      = $clog2(TOTAL_WORDS),
    localparam int SEC_CNT     = sector_count(BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT),
    localparam int SEC_W       = $clog2(SEC_CNT)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        bank,
    output logic [SEC_W-1:0]  sector,
    output logic              edge_boot
);
    localparam int NUM_BOUNDS    = 3;
    localparam int LOW_BOOT_END  = BOOT_CNT << SMALL_W;
    localparam int HIGH_BOOT_BAS = TOTAL_WORDS - (BOOT_CNT << SMALL_W);
    localparam int HIGH_BOOT_SEC = SEC_CNT - BOOT_CNT;
    localparam int PROT_LOW      = 2;

    logic [31:0]           a_ext;
    logic [NUM_BOUNDS-1:0] above;
    logic [31:0]           sec_ext;

    assign a_ext = 32'(addr);

    // One comparator per bank boundary; thermometer code selects the bank.
    for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_bound
        localparam int LIMIT = bank_top(i, SMALL_W, BIG_W, BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT);
        assign above[i] = (a_ext >= 32'(LIMIT));
    end

    always_comb begin
        case (above)
            3'b000:  bank = 2'd0;
            3'b001:  bank = 2'd1;
            3'b011:  bank = 2'd2;
            3'b111:  bank = 2'd3;
            default: bank = 2'd0;
        endcase
    end

    // Small sectors at both ends, large sectors everywhere between.
    always_comb begin
        if (a_ext < 32'(LOW_BOOT_END)) begin
            sec_ext = a_ext >> SMALL_W;
        end else if (a_ext < 32'(HIGH_BOOT_BAS)) begin
            sec_ext = 32'(BOOT_CNT) + ((a_ext - 32'(LOW_BOOT_END)) >> BIG_W);
        end else begin
            sec_ext = 32'(HIGH_BOOT_SEC) + ((a_ext - 32'(HIGH_BOOT_BAS)) >> SMALL_W);
        end
    end

    assign sector    = SEC_W'(sec_ext);
    assign edge_boot = (sec_ext < 32'(PROT_LOW)) || (sec_ext >= 32'(SEC_CNT - PROT_LOW));

endmodule

// File: rtl/flash_read_steer.sv
module flash_read_steer
    import flash_map_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic [1:0]       bank,
    input  logic [SEC_W-1:0] sector,
    input  logic             busy_valid,
    input  logic [1:0]       busy_bank,
    input  susp_e            susp,
    input  logic             erase_hit,
    input  logic [SEC_W-1:0] prog_sector,
    output rd_src_e          src
);
    logic same_bank;
    logic blocked;

    assign same_bank = busy_valid && (busy_bank == bank);

    always_comb begin
        case (susp)
            SUSP_ERASE: blocked = erase_hit;
            SUSP_PROG:  blocked = (sector == prog_sector);
            default:    blocked = 1'b1;
        endcase
    end

    assign src = (same_bank && blocked) ? SRC_STATUS : SRC_ARRAY;

endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
    import flash_map_pkg::*;
(
    input  req_kind_e kind,
    input  logic      edge_boot,
    input  logic      wp_n,
    input  logic      lock_hit,
    input  logic      erase_hit,
    input  logic      busy_valid,
    input  susp_e     susp,
    output deny_t     deny,
    output logic      permit
);
    always_comb begin
        deny.lock_hit    = lock_hit;
        deny.wp_hit      = !wp_n && edge_boot;
        deny.busy_hit    = busy_valid && ((susp == SUSP_NONE) || (susp == SUSP_RSVD));
        deny.suspend_hit = 1'b0;
        if (busy_valid) begin
            case (susp)
                SUSP_PROG:  deny.suspend_hit = 1'b1;
                SUSP_ERASE: deny.suspend_hit = (kind == REQ_ERASE) || erase_hit;
                default:    deny.suspend_hit = 1'b0;
            endcase
        end
    end

    assign permit = is_write_kind(kind) && (deny == '0);

endmodule

// File: rtl/flash_bank_arbiter.sv
module flash_bank_arbiter
    import flash_map_pkg::*;
#(
    parameter int SMALL_W      = 12,
    parameter int BIG_W        = 15,
    parameter int BOOT_CNT     = 8,
    parameter int EDGE_BIG_CNT = 15,
    parameter int MID_BIG_CNT  = 48,
    localparam int TOTAL_WORDS = bank_top(3, SMALL_W, BIG_W, BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT),
    localparam int ADDR_W      = $clog2(TOTAL_WORDS),
    localparam int SEC_CNT     = sector_count(BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT),
    localparam int SEC_W       = $clog2(SEC_CNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_kind,
    input  logic               busy_valid,
    input  logic [1:0]         busy_bank,
    input  logic [1:0]         susp_mode,
    input  logic [SEC_CNT-1:0] erase_sel,
    input  logic [SEC_W-1:0]   prog_sector,
    input  logic               wp_n,
    input  logic [SEC_CNT-1:0] lock_map,
    output logic               out_valid,
    output logic [1:0]         out_bank,
    output logic [SEC_W-1:0]   out_sector,
    output logic               out_status_sel,
    output logic               out_permit
);
    localparam int PAD_W = 1 << SEC_W;

    logic [1:0]       dec_bank;
    logic [SEC_W-1:0] dec_sector;
    logic             dec_edge;
    logic [PAD_W-1:0] erase_pad;
    logic [PAD_W-1:0] lock_pad;
    logic             erase_hit;
    logic             lock_hit;
    rd_src_e          rd_src;
    deny_t            deny;
    logic             wr_permit;
    req_kind_e        kind;
    susp_e            susp;

    assign kind      = req_kind_e'(req_kind);
    assign susp      = susp_e'(susp_mode);
    assign erase_pad = PAD_W'(erase_sel);
    assign lock_pad  = PAD_W'(lock_map);
    assign erase_hit = erase_pad[dec_sector];
    assign lock_hit  = lock_pad[dec_sector];

    flash_sector_decode #(
        .SMALL_W(SMALL_W), .BIG_W(BIG_W), .BOOT_CNT(BOOT_CNT),
        .EDGE_BIG_CNT(EDGE_BIG_CNT), .MID_BIG_CNT(MID_BIG_CNT)
    ) u_decode (
        .addr      (req_addr),
        .bank      (dec_bank),
        .sector    (dec_sector),
        .edge_boot (dec_edge)
    );

    flash_read_steer #(.SEC_W(SEC_W)) u_steer (
        .bank        (dec_bank),
        .sector      (dec_sector),
        .busy_valid  (busy_valid),
        .busy_bank   (busy_bank),
        .susp        (susp),
        .erase_hit   (erase_hit),
        .prog_sector (prog_sector),
        .src         (rd_src)
    );

    flash_write_guard u_guard (
        .kind       (kind),
        .edge_boot  (dec_edge),
        .wp_n       (wp_n),
        .lock_hit   (lock_hit),
        .erase_hit  (erase_hit),
        .busy_valid (busy_valid),
        .susp       (susp),
        .deny       (deny),
        .permit     (wr_permit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_bank       <= '0;
            out_sector     <= '0;
            out_status_sel <= 1'b0;
            out_permit     <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_bank       <= dec_bank;
                out_sector     <= dec_sector;
                out_status_sel <= (kind == REQ_READ || kind == REQ_RSVD) && (rd_src == SRC_STATUS);
                out_permit     <= wr_permit;
            end
        end
    end

endmodule

// File: rtl/flash_bank_arbiter_chk.sv
module flash_bank_arbiter_chk
    import flash_map_pkg::*;
#(
    parameter int SMALL_W      = 12,
    parameter int BIG_W        = 15,
    parameter int BOOT_CNT     = 8,
    parameter int EDGE_BIG_CNT = 15,
    parameter int MID_BIG_CNT  = 48,
    localparam int SEC_CNT     = sector_count(BOOT_CNT, EDGE_BIG_CNT, MID_BIG_CNT),
    localparam int SEC_W       = $clog2(SEC_CNT)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic               busy_valid,
    input logic [1:0]         busy_bank,
    input logic [1:0]         susp_mode,
    input logic               wp_n,
    input logic [SEC_CNT-1:0] lock_map,
    input logic               out_valid,
    input logic [1:0]         out_bank,
    input logic [SEC_W-1:0]   out_sector,
    input logic               out_status_sel,
    input logic               out_permit
);
    localparam int PAD_W     = 1 << SEC_W;
    localparam int EDGE_SECS = BOOT_CNT + EDGE_BIG_CNT;

    logic [1:0]       kind_q;
    logic             busy_q;
    logic [1:0]       bbank_q;
    logic [1:0]       susp_q;
    logic             wp_q;
    logic [PAD_W-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= '0;
            busy_q  <= 1'b0;
            bbank_q <= '0;
            susp_q  <= '0;
            wp_q    <= 1'b1;
            lock_q  <= '0;
        end else if (req_valid) begin
            kind_q  <= req_kind;
            busy_q  <= busy_valid;
            bbank_q <= busy_bank;
            susp_q  <= susp_mode;
            wp_q    <= wp_n;
            lock_q  <= PAD_W'(lock_map);
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    assert_read_no_permit_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && kind_q != 2'd1 && kind_q != 2'd2) |-> !out_permit);
    assert_status_only_busy_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status_sel) |-> (busy_q && bbank_q == out_bank));
    assert_single_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_permit) |-> (!busy_q || susp_q == 2'd1));
    assert_prog_susp_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_permit && busy_q) |-> (susp_q != 2'd2));
    assert_lock_denies_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_permit) |-> !lock_q[out_sector]);
    assert_wp_denies_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_permit && !wp_q) |->
        (out_sector >= SEC_W'(2) && out_sector < SEC_W'(SEC_CNT - 2)));
    assert_low_bank_range_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bank == 2'd0) |-> (out_sector < SEC_W'(EDGE_SECS)));
    assert_high_bank_range_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bank == 2'd3) |-> (out_sector >= SEC_W'(SEC_CNT - EDGE_SECS)));

endmodule

bind flash_bank_arbiter flash_bank_arbiter_chk #(
    .SMALL_W(SMALL_W), .BIG_W(BIG_W), .BOOT_CNT(BOOT_CNT),
    .EDGE_BIG_CNT(EDGE_BIG_CNT), .MID_BIG_CNT(MID_BIG_CNT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .busy_valid     (busy_valid),
    .busy_bank      (busy_bank),
    .susp_mode      (susp_mode),
    .wp_n           (wp_n),
    .lock_map       (lock_map),
    .out_valid      (out_valid),
    .out_bank       (out_bank),
    .out_sector     (out_sector),
    .out_status_sel (out_status_sel),
    .out_permit     (out_permit)
);

// File: tb/flash_bank_arbiter_bench.sv
module flash_bank_arbiter_bench;

    localparam int NSEC = 142;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [21:0]     req_addr = '0;
    logic [1:0]      req_kind = '0;
    logic            busy_valid = 1'b0;
    logic [1:0]      busy_bank = '0;
    logic [1:0]      susp_mode = '0;
    logic [NSEC-1:0] erase_sel = '0;
    logic [7:0]      prog_sector = '0;
    logic            wp_n = 1'b1;
    logic [NSEC-1:0] lock_map = '0;
    logic            out_valid;
    logic [1:0]      out_bank;
    logic [7:0]      out_sector;
    logic            out_status_sel;
    logic            out_permit;

    int n_vec = 0;
    int n_bad = 0;
    int sbase [NSEC];
    int ssize [NSEC];

    always #10 clk = ~clk;

    flash_bank_arbiter u_flash_bank_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .busy_valid(busy_valid), .busy_bank(busy_bank),
        .susp_mode(susp_mode), .erase_sel(erase_sel), .prog_sector(prog_sector),
        .wp_n(wp_n), .lock_map(lock_map), .out_valid(out_valid),
        .out_bank(out_bank), .out_sector(out_sector),
        .out_status_sel(out_status_sel), .out_permit(out_permit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one request; outputs are sampled one negedge later.
    task automatic issue(input int addr, input logic [1:0] kind);
        @(negedge clk);
        req_addr  = 22'(addr);
        req_kind  = kind;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int bank_of(input int s);
        if (s < 23) return 0;
        if (s < 71) return 1;
        if (s < 119) return 2;
        return 3;
    endfunction

    function automatic int mid_of(input int s);
        return sbase[s] + ssize[s] / 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int acc;
        acc = 0;
        for (int s = 0; s < NSEC; s++) begin
            ssize[s] = (s < 8 || s >= 134) ? 4096 : 32768;
            sbase[s] = acc;
            acc += ssize[s];
        end

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 permit", int'(out_permit), 0);
        chk("R1 status", int'(out_status_sel), 0);
        chk("R1 bank", int'(out_bank), 0);
        chk("R1 sector", int'(out_sector), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after release", int'(out_valid), 0);

        // R3 R4 R5 R12: map sweep over first, middle, last word of each sector
        for (int s = 0; s < NSEC; s++) begin
            for (int k = 0; k < 3; k++) begin
                int a;
                a = (k == 0) ? sbase[s] : (k == 1) ? mid_of(s) : sbase[s] + ssize[s] - 1;
                issue(a, 2'd0);
                chk("R2 valid", int'(out_valid), 1);
                chk("R4 sector", int'(out_sector), s);
                chk("R3 bank", int'(out_bank), bank_of(s));
                chk("R5 array idle", int'(out_status_sel), 0);
                chk("R12 read permit", int'(out_permit), 0);
            end
        end
        @(negedge clk);
        chk("R2 valid low", int'(out_valid), 0);

        // R12 free writes
        issue(sbase[50], 2'd1);
        chk("R12 program free", int'(out_permit), 1);
        issue(sbase[100], 2'd2);
        chk("R12 erase free", int'(out_permit), 1);

        // R5 R6 R9: busy bank, no suspend
        busy_valid = 1'b1;
        susp_mode  = 2'd0;
        for (int bb = 0; bb < 4; bb++) begin
            busy_bank = 2'(bb);
            for (int s = 10; s < NSEC; s += 40) begin
                issue(mid_of(s), 2'd0);
                if (bank_of(s) == bb) chk("R6 status busy", int'(out_status_sel), 1);
                else chk("R5 array other bank", int'(out_status_sel), 0);
                issue(mid_of(s), 2'd1);
                chk("R9 program denied", int'(out_permit), 0);
                issue(mid_of(s), 2'd2);
                chk("R9 erase denied", int'(out_permit), 0);
            end
        end

        // R7 erase suspend in bank 1, sectors 30 and 31 selected
        busy_bank = 2'd1;
        susp_mode = 2'd1;
        erase_sel = '0;
        erase_sel[30] = 1'b1;
        erase_sel[31] = 1'b1;
        for (int s = 28; s < 34; s++) begin
            issue(mid_of(s), 2'd0);
            chk("R7 read steer", int'(out_status_sel), (s == 30 || s == 31) ? 1 : 0);
            issue(mid_of(s), 2'd1);
            chk("R7 program", int'(out_permit), (s == 30 || s == 31) ? 0 : 1);
            issue(mid_of(s), 2'd2);
            chk("R7 erase denied", int'(out_permit), 0);
        end
        issue(mid_of(10), 2'd0);
        chk("R7 other bank read", int'(out_status_sel), 0);
        issue(mid_of(90), 2'd1);
        chk("R7 other bank program", int'(out_permit), 1);
        erase_sel = '0;

        // R8 program suspend in bank 2, sector 80
        busy_bank   = 2'd2;
        susp_mode   = 2'd2;
        prog_sector = 8'd80;
        for (int s = 78; s < 83; s++) begin
            issue(mid_of(s), 2'd0);
            chk("R8 read steer", int'(out_status_sel), (s == 80) ? 1 : 0);
            issue(mid_of(s), 2'd1);
            chk("R8 program denied", int'(out_permit), 0);
        end
        issue(mid_of(20), 2'd0);
        chk("R8 other bank read", int'(out_status_sel), 0);
        issue(mid_of(20), 2'd2);
        chk("R8 erase denied", int'(out_permit), 0);
        busy_valid = 1'b0;
        susp_mode  = 2'd0;

        // R10 write protect pin
        wp_n = 1'b0;
        for (int s = 0; s < NSEC; s++) begin
            issue(sbase[s], 2'd1);
            chk("R10 wp low program", int'(out_permit), (s < 2 || s > 139) ? 0 : 1);
        end
        issue(sbase[141], 2'd2);
        chk("R10 wp low erase top", int'(out_permit), 0);
        issue(sbase[2], 2'd2);
        chk("R10 wp low erase sector 2", int'(out_permit), 1);
        wp_n = 1'b1;
        issue(sbase[0], 2'd1);
        chk("R10 wp high sector 0", int'(out_permit), 1);
        issue(sbase[141], 2'd2);
        chk("R10 wp high sector 141", int'(out_permit), 1);

        // R11 one lock bit at a time
        for (int s = 0; s < NSEC; s++) begin
            lock_map    = '0;
            lock_map[s] = 1'b1;
            issue(mid_of(s), 2'd1);
            chk("R11 locked program", int'(out_permit), 0);
            issue(mid_of(s), 2'd2);
            chk("R11 locked erase", int'(out_permit), 0);
            issue(mid_of((s + 1) % NSEC), 2'd1);
            chk("R11 neighbour free", int'(out_permit), 1);
        end
        lock_map = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule